// File: doc/BRIEF.md
# Load/Store Alignment and Endian Steering Unit

This block sits between a core's load/store stage and a 64-bit, byte-addressable data memory port. Each request carries a byte address, a size code (byte, halfword, word or doubleword), a load/store flag, a signed-load flag, store data and a per-request endianness select. For stores the block places the operand into the correct byte lanes of a 64-bit memory word and raises one byte enable for each byte written. For loads it picks the addressed bytes out of the returned memory word, puts them in operand order, and fills the upper result bits with zeros or with copies of the operand's sign bit.

Every request is checked for natural alignment. A misaligned request is stopped before it reaches memory: no memory request goes out, no byte enable is raised, and the load result register keeps its value. A trap flag is returned in its place, so the faulting access leaves no side effect and the exception stays precise.

The memory port is combinational. The memory word for the request's doubleword address is expected on `mem_rdata` in the same cycle. The response (valid, trap, load data) is registered and appears one cycle after the request.

Top module: `lsu_align_steer`

## Requirements
- R1: While reset is held (rst_n low at a clock edge) and after it, until the first request, rsp_valid and rsp_trap are 0 and rsp_data is all zeros.
- R2: Size codes are 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 doubleword, so an operand is 2^size bytes. A request is misaligned when any of the low `size` address bits is 1. Byte requests are never misaligned.
- R3: A valid misaligned request drives mem_req, mem_we and every bit of mem_be low in its own cycle. In the next cycle rsp_valid and rsp_trap are 1.
- R4: A valid aligned store raises mem_req and mem_we, and raises mem_be bits offset to offset+2^size-1, where offset is address bits [2:0]. A load raises mem_req with mem_we low and mem_be all zero.
- R5: Little-endian store (req_big_endian=0): operand byte k (k=0 is the least significant) goes to memory lane offset+k. Lane j is mem_wdata[8j+7:8j] and holds byte address 8*word+j.
- R6: Big-endian store (req_big_endian=1): operand byte k goes to lane offset+2^size-1-k, so the most significant byte sits at the lowest address.
- R7: Little-endian aligned load: result byte k is taken from mem_rdata lane offset+k, for k below 2^size.
- R8: Big-endian aligned load: result byte k is taken from lane offset+2^size-1-k.
- R9: Above the operand, an unsigned load (req_signed=0) fills the result with zeros. A signed load fills it with copies of the operand's top bit. A doubleword load is not extended.
- R10: rsp_valid is 1 exactly in the cycle after a cycle with req_valid=1. After an aligned load, rsp_data holds the extracted value in that cycle.
- R11: rsp_data keeps its previous value after a trapped request, after a store, and in idle cycles.
- R12: mem_word_addr equals req_addr shifted right by 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 doubleword |
| req_store | input | 1 | 1 store, 0 load |
| req_signed | input | 1 | Sign-extend load result |
| req_big_endian | input | 1 | 1 big-endian lane mapping, 0 little-endian |
| req_wdata | input | DATA_W | Store operand, right-justified |
| mem_req | output | 1 | Memory access issued (aligned valid request) |
| mem_we | output | 1 | Memory write |
| mem_word_addr | output | ADDR_W-3 | Doubleword address |
| mem_be | output | DATA_W/8 | Byte enables, bit j for lane j |
| mem_wdata | output | DATA_W | Lane-steered store data |
| mem_rdata | input | DATA_W | Memory word for mem_word_addr, same cycle |
| rsp_valid | output | 1 | Response for previous cycle's request |
| rsp_trap | output | 1 | Previous request was misaligned |
| rsp_data | output | DATA_W | Load result register |

## Verification
On every cycle the assertions check the properties that hold at the interface whatever the data: a memory request only goes out for a naturally aligned address, the number of byte enables matches the operand size and only stores raise any, the response valid follows the request one cycle later, and a trap response leaves the result register unchanged. Only the bench scenarios can show the values of the data: which lane each operand byte lands in under either endianness, that a store followed by a load of the other endianness returns the bytes reversed, that the sign fill is correct at the byte, half and word boundaries, and that a trapped store leaves memory untouched.

// File: rtl/lsu_pkg.sv
// Shared types for the load/store alignment and steering unit.
// Assumes a 64-bit memory word: the largest size code selects eight bytes.
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } acc_size_e;

    // Operand length in bytes for a size code.
    function automatic int size_bytes(acc_size_e s);
        return 1 << s;
    endfunction

endpackage

// File: rtl/lsu_align_chk.sv
// Natural-alignment detector.
// Flags a request whose byte offset is not a multiple of the operand size.
// Assumes size codes no larger than the offset width allows.
module lsu_align_chk
    import lsu_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input  logic [OFF_W-1:0] offset,
    input  acc_size_e        size,
    output logic             misaligned
);

    logic [OFF_W-1:0] low_mask;

    // Build a mask of the offset bits that must be zero for this size.
    always_comb begin
        for (int b = 0; b < OFF_W; b++) begin
            low_mask[b] = (b < int'(size));
        end
    end

    // Any selected offset bit set means the operand straddles its natural slot.
    assign misaligned = |(offset & low_mask);

endmodule

// File: rtl/lsu_store_steer.sv
// Store lane steering.
// Places the right-justified operand bytes into memory byte lanes using either
// endian mapping, and raises one byte enable for each byte written.
// Assumes offset+operand length never passes the word end (alignment already checked).
module lsu_store_steer
    import lsu_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int OFF_W  = 3
) (
    input  logic [OFF_W-1:0]    offset,
    input  acc_size_e           size,
    input  logic                big_endian,
    input  logic                enable,
    input  logic [NBYTES*8-1:0] wdata,
    output logic [NBYTES-1:0]   be,
    output logic [NBYTES*8-1:0] lane_data
);

    // For every lane, pick the operand byte that belongs there.
    always_comb begin
        int               nb;
        int               off;
        logic [OFF_W-1:0] src;
        be        = '0;
        lane_data = '0;
        src       = '0;
        nb        = size_bytes(size);
        off       = int'(offset);
        for (int j = 0; j < NBYTES; j++) begin
            if (j >= off && j < off + nb) begin
                if (big_endian) begin
                    src = OFF_W'(off + nb - 1 - j);
                end else begin
                    src = OFF_W'(j - off);
                end
                be[j]              = enable;
                lane_data[j*8 +: 8] = wdata[src*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
// Load extraction and extension.
// Gathers the addressed bytes from a memory word into operand order for the
// chosen endianness, then zero- or sign-fills the rest of the result.
// Assumes an aligned request.
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int OFF_W  = 3
) (
    input  logic [OFF_W-1:0]    offset,
    input  acc_size_e           size,
    input  logic                big_endian,
    input  logic                sign_ext,
    input  logic [NBYTES*8-1:0] lane_data,
    output logic [NBYTES*8-1:0] result
);

    // Gather operand bytes, then fill the upper bytes from the operand's top bit.
    always_comb begin
        int               nb;
        int               off;
        logic [OFF_W-1:0] src;
        logic             top;
        result = '0;
        src    = '0;
        nb     = size_bytes(size);
        off    = int'(offset);
        for (int k = 0; k < NBYTES; k++) begin
            if (k < nb) begin
                if (big_endian) begin
                    src = OFF_W'(off + nb - 1 - k);
                end else begin
                    src = OFF_W'(off + k);
                end
                result[k*8 +: 8] = lane_data[src*8 +: 8];
            end
        end
        top = sign_ext & result[nb*8 - 1];
        for (int k = 0; k < NBYTES; k++) begin
            if (k >= nb) begin
                result[k*8 +: 8] = {8{top}};
            end
        end
    end

endmodule

// File: rtl/lsu_align_steer.sv
// Load/store alignment and endian steering unit (top).
// Passes aligned requests to a combinational memory port with lane-steered
// store data and byte enables. Misaligned requests are blocked and reported as
// a trap. Load results are registered and answer one cycle after the request.
// Assumes DATA_W is 64 (size code 3 is a full word) and that mem_rdata carries
// the word at mem_word_addr in the request cycle.
module lsu_align_steer
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [1:0]                   req_size,
    input  logic                         req_store,
    input  logic                         req_signed,
    input  logic                         req_big_endian,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_word_addr,
    output logic [DATA_W/8-1:0]          mem_be,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic                         rsp_valid,
    output logic                         rsp_trap,
    output logic [DATA_W-1:0]            rsp_data
);

    localparam int NBYTES = DATA_W / 8;
    localparam int OFF_W  = $clog2(NBYTES);

    acc_size_e        size_q;
    logic [OFF_W-1:0] offset;
    logic             misaligned;
    logic [DATA_W-1:0] load_value;

    // Decode the request fields used by every sub-block.
    assign size_q = acc_size_e'(req_size);
    assign offset = req_addr[OFF_W-1:0];

    lsu_align_chk #(
        .OFF_W (OFF_W)
    ) u_align (
        .offset     (offset),
        .size       (size_q),
        .misaligned (misaligned)
    );

    // Issue to memory only when the access is legal.
    assign mem_req       = req_valid & ~misaligned;
    assign mem_we        = mem_req & req_store;
    assign mem_word_addr = req_addr[ADDR_W-1:OFF_W];

    lsu_store_steer #(
        .NBYTES (NBYTES),
        .OFF_W  (OFF_W)
    ) u_store (
        .offset     (offset),
        .size       (size_q),
        .big_endian (req_big_endian),
        .enable     (mem_we),
        .wdata      (req_wdata),
        .be         (mem_be),
        .lane_data  (mem_wdata)
    );

    lsu_load_extract #(
        .NBYTES (NBYTES),
        .OFF_W  (OFF_W)
    ) u_load (
        .offset     (offset),
        .size       (size_q),
        .big_endian (req_big_endian),
        .sign_ext   (req_signed),
        .lane_data  (mem_rdata),
        .result     (load_value)
    );

    // Register the response; the result only moves on a legal load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_trap  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_trap  <= req_valid & misaligned;
            if (mem_req && !req_store) begin
                rsp_data <= load_value;
            end
        end
    end

endmodule

// File: rtl/lsu_align_steer_chk.sv
// Interface checker for lsu_align_steer, attached by bind.
// Watches the request, memory and response ports only.
module lsu_align_steer_chk #(
    parameter int OFF_W  = 3,
    parameter int NBYTES = 8,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OFF_W-1:0]  req_off,
    input logic [1:0]        req_size,
    input logic              mem_req,
    input logic              mem_we,
    input logic [NBYTES-1:0] mem_be,
    input logic              rsp_valid,
    input logic              rsp_trap,
    input logic [DATA_W-1:0] rsp_data
);

    logic [OFF_W-1:0] size_mask;
    logic             aligned;

    // Offset bits that must be clear for the requested size.
    assign size_mask = OFF_W'((1 << req_size) - 1);
    assign aligned   = ((req_off & size_mask) == '0);

    // R3
    no_access_when_misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> aligned);

    // R2
    aligned_request_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && aligned) |-> mem_req);

    // R4
    store_enable_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == (1 << req_size)));

    // R4
    no_enable_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_be == '0));

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11
    trap_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_data == $past(rsp_data)));

    // R3
    trap_is_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> rsp_valid);

endmodule

bind lsu_align_steer lsu_align_steer_chk #(
    .OFF_W  (OFF_W),
    .NBYTES (NBYTES),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_off   (req_addr[OFF_W-1:0]),
    .req_size  (req_size),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .rsp_valid (rsp_valid),
    .rsp_trap  (rsp_trap),
    .rsp_data  (rsp_data)
);

// File: tb/lsu_align_steer_tb.sv
`timescale 1ns/1ps
module lsu_align_steer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_store;
    logic        req_signed;
    logic        req_big_endian;
    logic [63:0] req_wdata;
    logic        mem_req;
    logic        mem_we;
    logic [28:0] mem_word_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata;
    logic        rsp_valid;
    logic        rsp_trap;
    logic [63:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] last_data;
    logic [63:0] mem [16];

    always #2.5 clk = ~clk;

    lsu_align_steer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_store(req_store), .req_signed(req_signed),
        .req_big_endian(req_big_endian), .req_wdata(req_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word_addr(mem_word_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_data(rsp_data)
    );

    // Memory model: combinational read, byte-enabled write at the clock edge.
    assign mem_rdata = mem[mem_word_addr[3:0]];
    always @(posedge clk) begin
        if (mem_we) begin
            for (int j = 0; j < 8; j++) begin
                if (mem_be[j]) mem[mem_word_addr[3:0]][j*8 +: 8] <= mem_wdata[j*8 +: 8];
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_mis(input logic [31:0] a, input logic [1:0] s);
        return (a[2:0] & 3'((1 << s) - 1)) != 3'd0;
    endfunction

    function automatic logic [7:0] exp_be(input logic [2:0] off, input logic [1:0] s);
        return 8'(((1 << (1 << s)) - 1) << off);
    endfunction

    function automatic logic [63:0] exp_lanes(input logic [63:0] d, input logic [2:0] off,
                                              input logic [1:0] s, input logic be);
        logic [63:0] r = '0;
        int n = 1 << s;
        for (int k = 0; k < n; k++) begin
            int lane = be ? (int'(off) + n - 1 - k) : (int'(off) + k);
            r[lane*8 +: 8] = d[k*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_load(input logic [63:0] w, input logic [2:0] off,
                                             input logic [1:0] s, input logic be, input logic sg);
        logic [63:0] r = '0;
        int n = 1 << s;
        for (int k = 0; k < n; k++) begin
            int lane = be ? (int'(off) + n - 1 - k) : (int'(off) + k);
            r[k*8 +: 8] = w[lane*8 +: 8];
        end
        if (sg && r[n*8-1]) begin
            for (int k = n; k < 8; k++) r[k*8 +: 8] = 8'hFF;
        end
        return r;
    endfunction

    // One access: drive at the falling edge, check memory side, then response.
    task automatic access(input logic [31:0] a, input logic [1:0] s, input logic st,
                          input logic sg, input logic be, input logic [63:0] d);
        logic        mis;
        logic [63:0] mask;
        logic [7:0]  ebe;
        req_valid = 1'b1; req_addr = a; req_size = s; req_store = st;
        req_signed = sg; req_big_endian = be; req_wdata = d;
        #0.5;
        mis = exp_mis(a, s);
        chk("R2 mem_req", 64'(mem_req), 64'(!mis));
        chk("R12 word addr", 64'(mem_word_addr), 64'(a >> 3));
        if (mis) begin
            chk("R3 no write/enables", {55'd0, mem_we, mem_be}, 64'd0);
        end else if (st) begin
            ebe = exp_be(a[2:0], s);
            chk("R4 store enables", 64'(mem_be), 64'(ebe));
            for (int j = 0; j < 8; j++) mask[j*8 +: 8] = {8{ebe[j]}};
            chk(be ? "R6 store lanes" : "R5 store lanes", mem_wdata & mask,
                exp_lanes(d, a[2:0], s, be) & mask);
        end else begin
            chk("R4 load no enables", {55'd0, mem_we, mem_be}, 64'd0);
            last_data = exp_load(mem[a[6:3]], a[2:0], s, be, sg);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R10 rsp_valid", 64'(rsp_valid), 64'd1);
        chk("R3 rsp_trap", 64'(rsp_trap), 64'(mis));
        chk(mis ? "R11 held on trap" : (st ? "R11 held on store" :
            (be ? "R8/R9 load data" : "R7/R9 load data")), rsp_data, last_data);
        req_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_store = 1'b0; req_signed = 1'b0; req_big_endian = 1'b0; req_wdata = '0;
        last_data = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {62'd0, rsp_valid, rsp_trap}, 64'd0);
        chk("R1 reset data", rsp_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {62'd0, rsp_valid, rsp_trap}, 64'd0);

        // R6 then R7/R8: big-endian word store read back both ways
        access(32'd12, 2'b10, 1'b1, 1'b0, 1'b1, 64'h11223344);
        chk("R6 memory bytes", mem[1][63:32], 32'h44332211);
        access(32'd12, 2'b10, 1'b0, 1'b0, 1'b0, 64'd0);
        chk("R7 swapped readback", rsp_data, 64'h44332211);
        access(32'd12, 2'b10, 1'b0, 1'b0, 1'b1, 64'd0);
        chk("R8 same-endian readback", rsp_data, 64'h11223344);

        // R9: sign and zero fill at byte, half and word sizes
        access(32'd3, 2'b00, 1'b1, 1'b0, 1'b0, 64'h80);
        access(32'd3, 2'b00, 1'b0, 1'b1, 1'b0, 64'd0);
        chk("R9 signed byte", rsp_data, 64'hFFFF_FFFF_FFFF_FF80);
        access(32'd3, 2'b00, 1'b0, 1'b0, 1'b0, 64'd0);
        chk("R9 unsigned byte", rsp_data, 64'h80);
        access(32'd16, 2'b01, 1'b1, 1'b0, 1'b0, 64'h8001);
        access(32'd16, 2'b01, 1'b0, 1'b1, 1'b0, 64'd0);
        chk("R9 signed half", rsp_data, 64'hFFFF_FFFF_FFFF_8001);
        access(32'd20, 2'b10, 1'b1, 1'b0, 1'b0, 64'h7FFF_FFFF);
        access(32'd20, 2'b10, 1'b0, 1'b1, 1'b0, 64'd0);
        chk("R9 positive word", rsp_data, 64'h7FFF_FFFF);

        // R3/R11: misaligned store leaves memory and result untouched
        access(32'd21, 2'b01, 1'b1, 1'b0, 1'b0, 64'hDEAD);
        chk("R3 memory untouched", mem[2][63:32], 32'h7FFF_FFFF);
        access(32'd36, 2'b11, 1'b0, 1'b0, 1'b0, 64'd0);
        access(32'd42, 2'b10, 1'b0, 1'b1, 1'b1, 64'd0);

        // R10/R11: idle cycle
        @(negedge clk);
        chk("R10 idle no response", 64'(rsp_valid), 64'd0);
        chk("R11 idle data held", rsp_data, last_data);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom_range(0, 3) != 0) a[2:0] = 3'(a[2:0] & ~3'($urandom_range(0, 7)));
            access(a, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), {$urandom, $urandom});
            if ($urandom_range(0, 7) == 0) @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule